// File: doc/BRIEF.md
# IPv4 Forwarding Fast-Path Header Processor

This block takes a whole 20-byte IPv4 header in one beat, together with the result of a route lookup. It returns a forwarding verdict for that header. Headers that are malformed, or that cannot be handled without software help, are tagged with a 3-bit reason code and diverted to the slow path unchanged. Every other header is forwarded. When the destination is not this router, the forwarded header has its time-to-live lowered by one and its header checksum patched incrementally. The incoming checksum is never verified. Skipping that check keeps the fast path short.

The header is a 160-bit vector with byte 0 of the datagram in bits 159:152. The fields used are:
- version: bits 159:156
- header length in 32-bit words: bits 155:152
- total length: bits 143:128
- TTL: bits 95:88
- protocol: bits 87:80
- checksum: bits 79:64
- destination address: bits 31:0

The block is fully pipelined and can accept one header per cycle. The result appears three register stages after the header is accepted. Backpressure on the output stalls every stage at once.

Top module: `ipv4_fastpath`

## Requirements
- R1: A header whose version (bits 159:156) is not 4 is rejected with code 1. So is a header whose length field (bits 155:152) is below 5, or whose total length (bits 143:128) is less than four times that length field.
- R2: A well-formed header whose length field is above 5 (it carries options) gets code 2.
- R3: A header presented with the route-hit input low gets code 3.
- R4: A header whose destination (bits 31:0) has 1110 in its top four bits (multicast) gets code 4.
- R5: A header whose total length exceeds the MTU parameter (default 1500) needs fragmentation and gets code 5. A total length equal to the MTU does not.
- R6: A header that is not locally destined and arrives with TTL (bits 95:88) of 0 or 1 gets code 6. A locally destined header is never given code 6.
- R7: When several conditions hold at once, the lowest code among them is reported. Code 0 means forward.
- R8: A forwarded header (code 0) that is not locally destined leaves with TTL reduced by one. Its checksum (bits 79:64) is the one's-complement incremental update for the changed word. All other bits are unchanged, and the tag output carries the next-hop input.
- R9: A forwarded header that is locally destined leaves bit-for-bit unchanged, with the next-hop tag.
- R10: The incoming checksum value never affects the code. A header with a wrong checksum is still forwarded.
- R11: A header with a nonzero code leaves bit-for-bit unchanged, with the tag output at zero.
- R12: With the output always ready, a header accepted at one clock edge gives out_valid after the third edge counted from that edge. A new header can be accepted at every edge.
- R13: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header beat offered |
| in_ready | output | 1 | Block can take a header this cycle |
| in_hdr | input | 160 | IPv4 header, byte 0 in the top bits |
| in_route_hit | input | 1 | Route lookup found an entry |
| in_local | input | 1 | Destination is this router |
| in_next_hop | input | TAG_W | Next-hop tag from the lookup |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_hdr | output | 160 | Outgoing header |
| out_tag | output | TAG_W | Next-hop tag, zero on exception |
| out_exc | output | 3 | Reason code, 0 = forward |

## Verification
A wrong classification register shows up as a wrong out_exc on the very result it belongs to, three edges after acceptance. A slip in the checksum or TTL datapath corrupts out_hdr on forwarded, non-local headers only. A stall-control fault shows as a lost, duplicated or reordered result. It can also show as outputs that change while held. Either way it is visible at the first transfer that follows. The bench compares every transfer in order against a reference model, under random valid and ready patterns.

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath #(
  parameter int TAG_W = 8,
  parameter int MTU   = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [159:0]     in_hdr,
  input  logic             in_route_hit,
  input  logic             in_local,
  input  logic [TAG_W-1:0] in_next_hop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [159:0]     out_hdr,
  output logic [TAG_W-1:0] out_tag,
  output logic [2:0]       out_exc
);
  localparam logic [15:0] MTU_L = 16'(MTU);

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic             s1_v, s1_hit, s1_loc;
  logic [159:0]     s1_hdr;
  logic [TAG_W-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else if (adv) s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_hdr <= in_hdr;
      s1_hit <= in_route_hit;
      s1_loc <= in_local;
      s1_tag <= in_next_hop;
    end
  end

  logic [3:0]  f_ver, f_ihl;
  logic [15:0] f_len;
  logic [7:0]  f_ttl;
  logic        c_bad, c_opt, c_miss, c_mc, c_frag, c_exp;
  logic [2:0]  code;

  assign f_ver  = s1_hdr[159:156];
  assign f_ihl  = s1_hdr[155:152];
  assign f_len  = s1_hdr[143:128];
  assign f_ttl  = s1_hdr[95:88];
  assign c_bad  = (f_ver != 4'd4) || (f_ihl < 4'd5) || (f_len < {10'b0, f_ihl, 2'b00});
  assign c_opt  = f_ihl != 4'd5;
  assign c_miss = !s1_hit;
  assign c_mc   = s1_hdr[31:28] == 4'hE;
  assign c_frag = f_len > MTU_L;
  assign c_exp  = !s1_loc && (f_ttl <= 8'd1);

  always_comb begin
    if (c_bad)       code = 3'd1;
    else if (c_opt)  code = 3'd2;
    else if (c_miss) code = 3'd3;
    else if (c_mc)   code = 3'd4;
    else if (c_frag) code = 3'd5;
    else if (c_exp)  code = 3'd6;
    else             code = 3'd0;
  end

  logic             s2_v, s2_dec;
  logic [2:0]       s2_code;
  logic [159:0]     s2_hdr;
  logic [TAG_W-1:0] s2_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (adv && s1_v) begin
      s2_hdr  <= s1_hdr;
      s2_code <= code;
      s2_dec  <= (code == 3'd0) && !s1_loc;
      s2_tag  <= (code == 3'd0) ? s1_tag : '0;
    end
  end

  logic [7:0]   ttl_n;
  logic [15:0]  w_old, w_new, ck_new;
  logic [159:0] hdr_fwd;

  assign ttl_n   = s2_hdr[95:88] - 8'd1;
  assign w_old   = s2_hdr[95:80];
  assign w_new   = {ttl_n, s2_hdr[87:80]};
  assign ck_new  = ~oc_add(oc_add(~s2_hdr[79:64], ~w_old), w_new);
  assign hdr_fwd = {s2_hdr[159:96], w_new, ck_new, s2_hdr[63:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= s2_v;
  end

  always_ff @(posedge clk) begin
    if (adv && s2_v) begin
      out_hdr <= s2_dec ? hdr_fwd : s2_hdr;
      out_tag <= s2_tag;
      out_exc <= s2_code;
    end
  end
endmodule

module ipv4_fastpath_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [159:0]     out_hdr,
  input logic [TAG_W-1:0] out_tag,
  input logic [2:0]       out_exc
);
  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_exc <= 3'd6);

  a_r11_tag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exc != 3'd0) |-> out_tag == '0);

  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1)) |-> out_valid);

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) && $stable(out_exc) && $stable(out_tag)));

  a_r13_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind ipv4_fastpath ipv4_fastpath_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
  .out_tag(out_tag), .out_exc(out_exc)
);

// File: tb/ipv4_fastpath_bench.sv
module ipv4_fastpath_bench;
  localparam int TAG_W = 8;
  localparam int MTU   = 1500;
  localparam int NDIR  = 24;
  localparam int NRND  = 700;
  localparam int N     = NDIR + NRND;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_route_hit = 1'b0, in_local = 1'b0;
  logic [159:0] in_hdr = '0;
  logic [TAG_W-1:0] in_next_hop = '0;
  logic out_valid, out_ready = 1'b0;
  logic [159:0] out_hdr;
  logic [TAG_W-1:0] out_tag;
  logic [2:0] out_exc;

  always #10 clk = ~clk;

  ipv4_fastpath #(.TAG_W(TAG_W), .MTU(MTU)) u_ipv4_fastpath (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_route_hit(in_route_hit), .in_local(in_local),
    .in_next_hop(in_next_hop), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_tag(out_tag), .out_exc(out_exc)
  );

  typedef struct {
    logic [159:0] hdr;
    logic hit, loc, ck_ok;
    logic [TAG_W-1:0] tag;
  } stim_t;

  typedef struct {
    logic [159:0] hdr;
    logic [TAG_W-1:0] tag;
    logic [2:0] exc;
    logic ck_ok;
  } exp_t;

  stim_t stim [N];
  exp_t  q [$];
  int nchk = 0, nfail = 0;
  int unsigned seed_dummy;

  function automatic logic [15:0] cks(input logic [159:0] h);
    logic [31:0] s = 0;
    h[79:64] = 16'h0;
    for (int i = 0; i < 10; i++) s += 32'(h[i*16 +: 16]);
    s = (s & 32'hFFFF) + (s >> 16);
    s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  function automatic logic [159:0] mk(input logic [3:0] ver, input logic [3:0] ihl,
      input logic [15:0] len, input logic [7:0] ttl, input logic [31:0] dst);
    logic [159:0] h;
    h = {ver, ihl, 8'h00, len, 16'h1c46, 16'h4000, ttl, 8'h06, 16'h0000, 32'h0a000001, dst};
    h[79:64] = cks(h);
    return h;
  endfunction

  function automatic logic [2:0] exp_code(input stim_t s);
    logic [3:0] v = s.hdr[159:156], l = s.hdr[155:152];
    logic [15:0] tl = s.hdr[143:128];
    if (v != 4 || l < 5 || tl < 16'(l) * 4) return 1;
    if (l != 5) return 2;
    if (!s.hit) return 3;
    if (s.hdr[31:28] == 4'hE) return 4;
    if (tl > MTU) return 5;
    if (!s.loc && s.hdr[95:88] <= 1) return 6;
    return 0;
  endfunction

  function automatic exp_t model(input stim_t s);
    exp_t e;
    e.exc = exp_code(s);
    e.hdr = s.hdr;
    e.ck_ok = s.ck_ok;
    e.tag = (e.exc == 0) ? s.tag : '0;
    if (e.exc == 0 && !s.loc) begin
      e.hdr[95:88] = s.hdr[95:88] - 1;
      e.hdr[79:64] = cks(e.hdr);
    end
    return e;
  endfunction

  function automatic string req_of(input exp_t e, input logic loc);
    case (e.exc)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6";
      default: return !e.ck_ok ? "R10" : (loc ? "R9" : "R8");
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic stim_t S(input logic [159:0] h, input logic hit, input logic loc);
    stim_t s;
    s.hdr = h; s.hit = hit; s.loc = loc; s.ck_ok = 1'b1; s.tag = 8'h5A;
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    exp_t e, pend;
    logic [159:0] held_hdr;
    logic [2:0] held_exc;
    bit holding;
    int idx, lat;
    seed_dummy = $urandom(32'd1234);

    // directed corners
    stim[0]  = S(mk(4'd6, 4'd5, 16'd60, 8'd64, 32'h0b000001), 1, 0);    // R1 version
    stim[1]  = S(mk(4'd4, 4'd4, 16'd60, 8'd64, 32'h0b000001), 1, 0);    // R1 ihl<5
    stim[2]  = S(mk(4'd4, 4'd5, 16'd19, 8'd64, 32'h0b000001), 1, 0);    // R1 short len
    stim[3]  = S(mk(4'd4, 4'd5, 16'd20, 8'd64, 32'h0b000001), 1, 0);    // len 20 ok
    stim[4]  = S(mk(4'd4, 4'd6, 16'd24, 8'd64, 32'h0b000001), 1, 0);    // R2
    stim[5]  = S(mk(4'd4, 4'd6, 16'd23, 8'd64, 32'h0b000001), 1, 0);    // R1 len<24
    stim[6]  = S(mk(4'd4, 4'd5, 16'd100, 8'd64, 32'h0b000001), 0, 0);   // R3
    stim[7]  = S(mk(4'd4, 4'd5, 16'd100, 8'd64, 32'he0000001), 1, 0);   // R4
    stim[8]  = S(mk(4'd4, 4'd5, 16'd100, 8'd64, 32'hefffffff), 1, 0);   // R4
    stim[9]  = S(mk(4'd4, 4'd5, 16'd100, 8'd64, 32'hf0000001), 1, 0);   // not mcast
    stim[10] = S(mk(4'd4, 4'd5, 16'(MTU), 8'd64, 32'h0b000001), 1, 0);  // R5 boundary ok
    stim[11] = S(mk(4'd4, 4'd5, 16'(MTU+1), 8'd64, 32'h0b000001), 1, 0);// R5
    stim[12] = S(mk(4'd4, 4'd5, 16'd100, 8'd1, 32'h0b000001), 1, 0);    // R6
    stim[13] = S(mk(4'd4, 4'd5, 16'd100, 8'd0, 32'h0b000001), 1, 0);    // R6
    stim[14] = S(mk(4'd4, 4'd5, 16'd100, 8'd1, 32'h0b000001), 1, 1);    // R9 local
    stim[15] = S(mk(4'd4, 4'd5, 16'd100, 8'd0, 32'h0b000001), 1, 1);    // R9 local
    stim[16] = S(mk(4'd4, 4'd5, 16'd100, 8'd2, 32'h0b000001), 1, 0);    // R8 ttl 2
    stim[17] = S(mk(4'd5, 4'd5, 16'd100, 8'd64, 32'h0b000001), 0, 0);   // R7 bad+miss
    stim[18] = S(mk(4'd4, 4'd7, 16'd100, 8'd64, 32'he0000005), 1, 0);   // R7 opt+mc
    stim[19] = S(mk(4'd4, 4'd5, 16'd100, 8'd64, 32'he0000005), 0, 0);   // R7 miss+mc
    stim[20] = S(mk(4'd4, 4'd5, 16'd2000, 8'd0, 32'he0000005), 1, 0);   // R7 mc+frag+ttl
    stim[21] = S(mk(4'd4, 4'd5, 16'd2000, 8'd0, 32'h0b000005), 1, 0);   // R7 frag+ttl
    stim[22] = S(mk(4'd4, 4'd5, 16'd100, 8'd255, 32'h0b000001), 1, 0);  // R8 ttl 255
    stim[23] = S(mk(4'd4, 4'd5, 16'd100, 8'd64, 32'h0b000001), 1, 0);   // R10 bad cks
    stim[23].hdr[79:64] = stim[23].hdr[79:64] ^ 16'h1234;
    stim[23].ck_ok = 1'b0;

    for (int i = NDIR; i < N; i++) begin
      logic [3:0] v, l;
      logic [15:0] tl;
      logic [7:0] t;
      logic [31:0] d;
      v  = ($urandom % 16 == 0) ? 4'($urandom) : 4'd4;
      l  = ($urandom % 10 == 0) ? 4'($urandom) : 4'd5;
      tl = ($urandom % 8 == 0) ? 16'($urandom % 64) : 16'(20 + $urandom % 1700);
      t  = ($urandom % 6 == 0) ? 8'($urandom % 3) : 8'($urandom);
      d  = ($urandom % 8 == 0) ? {4'hE, 28'($urandom)} : $urandom;
      stim[i] = S(mk(v, l, tl, t, d), ($urandom % 10) != 0, ($urandom % 5) == 0);
      stim[i].tag = 8'($urandom);
    end

    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R12", "reset out_valid", 160'(out_valid), 160'(0));
    check(in_ready === 1'b1, "R12", "reset in_ready", 160'(in_ready), 160'(1));
    rst_n = 1'b1;

    // R12 latency, directed
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_hdr = stim[16].hdr; in_route_hit = 1; in_local = 0; in_next_hop = stim[16].tag;
    pend = model(stim[16]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
    check(lat == 3, "R12", "latency", 160'(lat), 160'(3));
    check(out_hdr === pend.hdr && out_exc === 3'd0, "R8", "latency header",
          out_hdr, pend.hdr);
    @(negedge clk);

    // main stream
    idx = 0;
    holding = 0;
    while (idx < N || q.size() != 0) begin
      @(negedge clk);
      if (holding)
        check(out_valid && out_hdr === held_hdr && out_exc === held_exc, "R13",
              "held output", out_hdr, held_hdr);
      out_ready = (idx < 40) ? 1'b1 : (($urandom % 4) != 0);
      in_valid  = (idx < N) && ((idx < 40) || ($urandom % 4) != 0);
      if (idx < N) begin
        in_hdr = stim[idx].hdr; in_route_hit = stim[idx].hit;
        in_local = stim[idx].loc; in_next_hop = stim[idx].tag;
      end
      #1;
      holding = out_valid && !out_ready;
      if (holding) begin
        held_hdr = out_hdr; held_exc = out_exc;
        check(!in_ready, "R13", "in_ready while stalled", 160'(in_ready), 160'(0));
      end
      if (out_valid && out_ready) begin
        logic [159:0] m;
        if (q.size() == 0) begin
          check(0, "R12", "unexpected output", out_hdr, 160'(0));
        end else begin
          string r;
          e = q.pop_front();
          r = req_of(e, 1'b0);
          m = e.ck_ok ? {160{1'b1}} : ~(160'hFFFF << 64);
          check(out_exc === e.exc, r, "code", 160'(out_exc), 160'(e.exc));
          check((out_hdr & m) === (e.hdr & m), (e.exc != 0) ? "R11" : r, "header",
                out_hdr, e.hdr);
          check(out_tag === e.tag, (e.exc != 0) ? "R11" : "R8", "tag",
                160'(out_tag), 160'(e.tag));
        end
      end
      if (in_valid && in_ready) begin
        q.push_back(model(stim[idx]));
        idx++;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule